// File: doc/BRIEF.md
# Programmable Panel Control-Pulse Generator

This block produces the control pulses that steer the row and column drivers of a flat panel. It works in the internal clock domain, where each clock carries a pair of pixels. A horizontal counter is restarted by each new active line, and a vertical counter is restarted by each frame. Every output channel owns a horizontal window, which compares against the pixel-pair count, and a vertical window, which compares against the line count. A per-channel mode merges the two windows with a chosen logic function and can invert the result.

The last channel is a dedicated blanking control. It drives its own output pin, which masks the column data bus while the data there may be random, for example in the clocks just before the start pulse. Software writes the channel settings through a small write port. The writes go into a staging bank and reach the active bank only when the next frame starts, so no frame ever uses a half-updated setup.

Top module: `panel_pulse_gen`

## Requirements
- R1: While `rst_n` is low, all `pulse_o` bits and `blank_o` read 0. After reset, both counters start at 0 and every setting is 0.
- R2: The horizontal counter loads 0 in the clock where `de_i` is high after being low. In every other clock it adds 1.
- R3: The line counter loads 0 in any clock where `frame_start_i` is high. Otherwise it adds 1 in each clock where `de_i` is low after being high. It holds at 2047 instead of wrapping.
- R4: A window is high exactly when start <= count < stop. If start >= stop, the window never goes high.
- R5: Mode select code 00 drives the output with the AND of the horizontal and vertical windows.
- R6: Mode select code 01 selects the OR of the two windows.
- R7: Mode select code 10 selects the XOR of the two windows.
- R8: Mode select code 11 selects the horizontal window alone.
- R9: Mode bit 2 inverts the channel output after the combination.
- R10: Each output is registered. It reflects the counter values held in the clock before the output changes.
- R11: A setting write lands in a staging bank. The active bank copies the staging bank only in a clock where `frame_start_i` is high.
- R12: Channel 8, the last index, is the blanking channel and appears on `blank_o`. Channels 0 to 7 appear on `pulse_o[7:0]`.
- R13: The write address is {channel[6:3], field[2:0]}. The field codes are: 0 horizontal start, 1 horizontal stop, 2 vertical start, 3 vertical stop, 4 mode {invert, select[1:0]}. Writes to field codes 5 to 7, or to a channel number of 9 or more, change nothing.
- R14: The horizontal counter holds at 1023 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, one pixel pair per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| de_i | input | 1 | Data enable, high during active pixels |
| frame_start_i | input | 1 | One-clock frame start indication |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 7 | Setting address {channel, field} |
| cfg_wdata_i | input | 11 | Setting write data |
| pulse_o | output | 8 | Control pulses of channels 0 to 7 |
| blank_o | output | 1 | Blanking mask from channel 8 |

## Verification
The embedded properties assume that `de_i` and `frame_start_i` are clean synchronous levels on `clk`, and that a setting write never falls in the same clock as a frame start. The stimulus meets these assumptions. It raises the frame start pulse only while `de_i` is low, and it issues every write during blanking, clear of any frame start clock. The saturation properties need long runs: one line longer than 1024 clocks, and one frame of more than 2048 lines. The stimulus supplies both, so the counters actually reach their limits.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic [1:0] {
        CMB_AND   = 2'b00,
        CMB_OR    = 2'b01,
        CMB_XOR   = 2'b10,
        CMB_HONLY = 2'b11
    } cmb_e;

    typedef enum logic [2:0] {
        FLD_HSTART = 3'd0,
        FLD_HSTOP  = 3'd1,
        FLD_VSTART = 3'd2,
        FLD_VSTOP  = 3'd3,
        FLD_MODE   = 3'd4
    } fld_e;

    localparam int FLD_W  = 3;
    localparam int MODE_W = 3;
endpackage

// File: rtl/ppg_counters.sv
module ppg_counters #(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              de_i,
    input  logic              frame_start_i,
    output logic [HCNT_W-1:0] hcnt_o,
    output logic [VCNT_W-1:0] vcnt_o
);
    localparam logic [HCNT_W-1:0] H_MAX = '1;
    localparam logic [VCNT_W-1:0] V_MAX = '1;

    typedef struct packed {
        logic              de;
        logic [HCNT_W-1:0] h;
        logic [VCNT_W-1:0] v;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.de = de_i;
        if (de_i && !st_q.de) begin
            st_d.h = '0;
        end else if (st_q.h != H_MAX) begin
            st_d.h = st_q.h + 1'b1;
        end
        if (frame_start_i) begin
            st_d.v = '0;
        end else if (!de_i && st_q.de && (st_q.v != V_MAX)) begin
            st_d.v = st_q.v + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hcnt_o = st_q.h;
    assign vcnt_o = st_q.v;

    AST_HCNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (de_i && !st_q.de) |=> (hcnt_o == '0));                          // R2
    AST_HCNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((hcnt_o == H_MAX) && !(de_i && !st_q.de)) |=> (hcnt_o == H_MAX)); // R14
    AST_VCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (vcnt_o == '0));                                 // R3
    AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && !de_i && st_q.de && (vcnt_o != V_MAX))
        |=> (vcnt_o == $past(vcnt_o) + 1'b1));                             // R3
endmodule

// File: rtl/ppg_cfg.sv
module ppg_cfg #(
    parameter int NUM_OUT = 9,
    parameter int HCNT_W  = 10,
    parameter int VCNT_W  = 11,
    parameter int CH_W    = 4,
    parameter int DW      = 11
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   frame_start_i,
    input  logic                                   we_i,
    input  logic [CH_W+ppg_pkg::FLD_W-1:0]         addr_i,
    input  logic [DW-1:0]                          wdata_i,
    output logic [NUM_OUT-1:0][HCNT_W-1:0]         hs_o,
    output logic [NUM_OUT-1:0][HCNT_W-1:0]         he_o,
    output logic [NUM_OUT-1:0][VCNT_W-1:0]         vs_o,
    output logic [NUM_OUT-1:0][VCNT_W-1:0]         ve_o,
    output logic [NUM_OUT-1:0][ppg_pkg::MODE_W-1:0] md_o
);
    import ppg_pkg::*;

    typedef struct packed {
        logic [NUM_OUT-1:0][HCNT_W-1:0] hs;
        logic [NUM_OUT-1:0][HCNT_W-1:0] he;
        logic [NUM_OUT-1:0][VCNT_W-1:0] vs;
        logic [NUM_OUT-1:0][VCNT_W-1:0] ve;
        logic [NUM_OUT-1:0][MODE_W-1:0] md;
    } bank_t;

    typedef struct packed {
        bank_t stg;
        bank_t act;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic [CH_W-1:0] ch_idx;
    fld_e            fld;

    assign ch_idx = addr_i[CH_W+FLD_W-1:FLD_W];
    assign fld    = fld_e'(addr_i[FLD_W-1:0]);

    always_comb begin
        st_d = st_q;
        if (frame_start_i) st_d.act = st_q.stg;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (we_i && (ch_idx == CH_W'(i))) begin
                case (fld)
                    FLD_HSTART: st_d.stg.hs[i] = wdata_i[HCNT_W-1:0];
                    FLD_HSTOP:  st_d.stg.he[i] = wdata_i[HCNT_W-1:0];
                    FLD_VSTART: st_d.stg.vs[i] = wdata_i[VCNT_W-1:0];
                    FLD_VSTOP:  st_d.stg.ve[i] = wdata_i[VCNT_W-1:0];
                    FLD_MODE:   st_d.stg.md[i] = wdata_i[MODE_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_o = st_q.act.hs;
    assign he_o = st_q.act.he;
    assign vs_o = st_q.act.vs;
    assign ve_o = st_q.act.ve;
    assign md_o = st_q.act.md;

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(st_q.act));                          // R11
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (st_q.act == $past(st_q.stg)));               // R11
endmodule

// File: rtl/ppg_channel.sv
module ppg_channel #(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HCNT_W-1:0]          hcnt_i,
    input  logic [VCNT_W-1:0]          vcnt_i,
    input  logic [HCNT_W-1:0]          hs_i,
    input  logic [HCNT_W-1:0]          he_i,
    input  logic [VCNT_W-1:0]          vs_i,
    input  logic [VCNT_W-1:0]          ve_i,
    input  logic [ppg_pkg::MODE_W-1:0] md_i,
    output logic                       pulse_o
);
    import ppg_pkg::*;

    typedef struct packed {
        logic pulse;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   hwin, vwin, merged;

    always_comb begin
        hwin = (hcnt_i >= hs_i) && (hcnt_i < he_i);
        vwin = (vcnt_i >= vs_i) && (vcnt_i < ve_i);
        case (cmb_e'(md_i[1:0]))
            CMB_AND:   merged = hwin & vwin;
            CMB_OR:    merged = hwin | vwin;
            CMB_XOR:   merged = hwin ^ vwin;
            default:   merged = hwin;
        endcase
        st_d.pulse = merged ^ md_i[2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    AST_EMPTY_HWIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((hs_i >= he_i) && (md_i == {1'b0, CMB_HONLY})) |=> !pulse_o);      // R4
    AST_AND_INSIDE_H: assert property (@(posedge clk) disable iff (!rst_n)
        ((md_i == {1'b0, CMB_AND}) && (hcnt_i < hs_i)) |=> !pulse_o);       // R5
endmodule

// File: rtl/panel_pulse_gen.sv
module panel_pulse_gen #(
    parameter int NUM_OUT = 9,
    parameter int HCNT_W  = 10,
    parameter int VCNT_W  = 11
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            de_i,
    input  logic                                            frame_start_i,
    input  logic                                            cfg_we_i,
    input  logic [$clog2(NUM_OUT)+ppg_pkg::FLD_W-1:0]       cfg_addr_i,
    input  logic [((VCNT_W > HCNT_W) ? VCNT_W : HCNT_W)-1:0] cfg_wdata_i,
    output logic [NUM_OUT-2:0]                              pulse_o,
    output logic                                            blank_o
);
    import ppg_pkg::*;

    localparam int CH_W = $clog2(NUM_OUT);
    localparam int DW   = (VCNT_W > HCNT_W) ? VCNT_W : HCNT_W;

    logic [HCNT_W-1:0]               hcnt;
    logic [VCNT_W-1:0]               vcnt;
    logic [NUM_OUT-1:0][HCNT_W-1:0]  hs, he;
    logic [NUM_OUT-1:0][VCNT_W-1:0]  vs, ve;
    logic [NUM_OUT-1:0][MODE_W-1:0]  md;
    logic [NUM_OUT-1:0]              chan_out;

    ppg_counters #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .de_i          (de_i),
        .frame_start_i (frame_start_i),
        .hcnt_o        (hcnt),
        .vcnt_o        (vcnt)
    );

    ppg_cfg #(
        .NUM_OUT(NUM_OUT), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W),
        .CH_W(CH_W), .DW(DW)
    ) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .we_i          (cfg_we_i),
        .addr_i        (cfg_addr_i),
        .wdata_i       (cfg_wdata_i),
        .hs_o          (hs),
        .he_o          (he),
        .vs_o          (vs),
        .ve_o          (ve),
        .md_o          (md)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        ppg_channel #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hcnt_i  (hcnt),
            .vcnt_i  (vcnt),
            .hs_i    (hs[g]),
            .he_i    (he[g]),
            .vs_i    (vs[g]),
            .ve_i    (ve[g]),
            .md_i    (md[g]),
            .pulse_o (chan_out[g])
        );
    end

    assign pulse_o = chan_out[NUM_OUT-2:0];
    assign blank_o = chan_out[NUM_OUT-1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> ((chan_out == '0) || !$past(rst_n) && rst_n));          // R1
endmodule

// File: tb/sim_panel_pulse_gen.sv
module sim_panel_pulse_gen;
    localparam int NCH = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        de = 1'b0;
    logic        fs = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [10:0] wdata = '0;
    logic [7:0]  pulse;
    logic        blank;

    always #5 clk = ~clk;

    panel_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .de_i(de), .frame_start_i(fs),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .pulse_o(pulse), .blank_o(blank)
    );

    typedef struct {
        int         due;
        logic [8:0] exp;
    } item_t;

    item_t q[$];
    int    n_run = 0, n_fail = 0, edges = 0;
    bit    done = 0;

    int m_h = 0, m_v = 0;
    bit m_de = 0;
    int stg_hs[NCH], stg_he[NCH], stg_vs[NCH], stg_ve[NCH], stg_md[NCH];
    int act_hs[NCH], act_he[NCH], act_vs[NCH], act_ve[NCH], act_md[NCH];
    string tag[NCH] = '{"R5 R2 R3", "R6 R11", "R7", "R8 R2", "R9",
                        "R4 R13", "R4 R3", "R14 R8", "R12 R5"};

    function automatic logic [8:0] predict();
        logic [8:0] r;
        for (int c = 0; c < NCH; c++) begin
            bit hw, vw, o;
            hw = (m_h >= act_hs[c]) && (m_h < act_he[c]);
            vw = (m_v >= act_vs[c]) && (m_v < act_ve[c]);
            case (act_md[c] & 3)
                0: o = hw & vw;
                1: o = hw | vw;
                2: o = hw ^ vw;
                default: o = hw;
            endcase
            r[c] = o ^ act_md[c][2];
        end
        return r;
    endfunction

    task automatic step(input bit d, input bit f, input bit w = 0,
                        input int ch = 0, input int fld = 0, input int val = 0);
        @(negedge clk);
        de = d; fs = f; we = w;
        addr = {ch[3:0], fld[2:0]};
        wdata = val[10:0];
        if (f) begin
            act_hs = stg_hs; act_he = stg_he; act_vs = stg_vs;
            act_ve = stg_ve; act_md = stg_md;
        end
        if (w && ch < NCH) begin
            case (fld)
                0: stg_hs[ch] = val & 1023;
                1: stg_he[ch] = val & 1023;
                2: stg_vs[ch] = val & 2047;
                3: stg_ve[ch] = val & 2047;
                4: stg_md[ch] = val & 7;
                default: ;
            endcase
        end
        if (d && !m_de) m_h = 0;
        else if (m_h != 1023) m_h++;
        if (f) m_v = 0;
        else if (!d && m_de && m_v != 2047) m_v++;
        m_de = d;
        q.push_back('{due: edges + 2, exp: predict()});
    endtask

    task automatic wr(input int ch, input int fld, input int val);
        step(0, 0, 1, ch, fld, val);
    endtask

    task automatic cfg_ch(input int ch, input int hs, input int he,
                          input int vs, input int ve, input int md);
        wr(ch, 0, hs); wr(ch, 1, he); wr(ch, 2, vs); wr(ch, 3, ve); wr(ch, 4, md);
    endtask

    task automatic line(input int act, input int idle);
        for (int i = 0; i < act; i++) step(1, 0);
        for (int i = 0; i < idle; i++) step(0, 0);
    endtask

    // Scoreboard monitor: compares every output one clock after its counters (R10)
    always @(posedge clk) begin
        edges++;
        #2;
        if (q.size() > 0 && q[0].due == edges) begin
            item_t it;
            logic [8:0] act;
            it = q.pop_front();
            act = {blank, pulse};
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                for (int c = 0; c < NCH; c++)
                    if (act[c] !== it.exp[c])
                        $display("FAIL %s R10 ch%0d cycle %0d: actual %b expected %b",
                                 tag[c], c, edges, act[c], it.exp[c]);
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            stg_hs[c] = 0; stg_he[c] = 0; stg_vs[c] = 0; stg_ve[c] = 0; stg_md[c] = 0;
            act_hs[c] = 0; act_he[c] = 0; act_vs[c] = 0; act_ve[c] = 0; act_md[c] = 0;
        end
        de = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs quiet in reset even with de high
        n_run++;
        if ({blank, pulse} !== 9'd0) begin
            n_fail++;
            $display("FAIL R1 reset outputs: actual %b expected %b", {blank, pulse}, 9'd0);
        end
        de = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        cfg_ch(0, 2, 10, 1, 3, 0);
        cfg_ch(1, 5, 15, 4, 5, 1);
        cfg_ch(2, 3, 20, 2, 4, 2);
        cfg_ch(3, 30, 35, 0, 0, 3);
        cfg_ch(4, 2, 10, 1, 3, 4);
        cfg_ch(5, 7, 7, 0, 3, 3);
        cfg_ch(6, 20, 10, 0, 6, 3);
        cfg_ch(7, 0, 1023, 0, 0, 7);
        cfg_ch(8, 24, 40, 0, 6, 0);
        // R13: unused field codes and channel numbers must change nothing
        wr(5, 5, 1); wr(5, 6, 0); wr(5, 7, 1); wr(12, 1, 40); wr(9, 4, 1);

        for (int fr = 0; fr < 3; fr++) begin
            step(0, 1);
            for (int ln = 0; ln < 6; ln++) begin
                line(40, 10);
                // R11: mid-frame rewrite, effective only from the next frame
                if (fr == 1 && ln == 2) begin wr(1, 0, 0); wr(1, 2, 0); end
            end
        end

        // R14: line longer than 1024 clocks
        step(0, 1);
        line(1100, 6);

        // R3: frame with more than 2048 lines, ch6 high only at line 2047
        cfg_ch(6, 0, 0, 0, 2047, 6);
        step(0, 1);
        for (int ln = 0; ln < 2052; ln++) line(2, 2);
        step(0, 1);
        line(4, 4);
        repeat (4) step(0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule